// File: doc/BRIEF.md
# Fully Associative Tag Lookup

This block is the tag side of a small fully associative cache. No address bits select an entry, so the whole request address is the tag. Every entry has its own comparator, and all entries are checked at once. A lookup returns a registered hit flag and an entry number. On a hit the number is the matching entry. On a miss it is the entry that a fill would use now.

A fill writes a tag into the chosen entry and sets that entry's valid flag. The fill prefers an empty entry. Only when every entry is in use does it evict the least recently used one. A flush empties the whole store in one cycle. Data storage, the memory side and the write policy are handled elsewhere. This block holds only tags, valid flags and the recency order.

Top module: `fa_tag_lookup`

## Requirements
- R1: The stored tag is the full ADDR_W-bit address. A lookup hits only when some valid entry holds exactly that address. A difference in any single bit gives a miss.
- R2: `rsp_valid` rises exactly one cycle after `lk_valid` and is low in every other cycle. `rsp_hit` and `rsp_idx` describe the store as it was in the request cycle.
- R3: On a miss, `rsp_idx` is the lowest-numbered invalid entry whenever at least one entry is invalid.
- R4: On a miss with every entry valid, `rsp_idx` is the least recently used entry.
- R5: A hitting lookup with no fill and no flush in the same cycle makes that entry the most recently used. The other entries keep their relative order.
- R6: A fill whose address is not present writes the address into the victim entry that R3 or R4 selects, marks the entry valid and makes it the most recently used.
- R7: A fill whose address already hits reuses that entry and makes it the most recently used. No address ever occupies two entries.
- R8: A flush clears every valid flag and restores the recency order to entry 0 oldest through entry ENTRIES-1 newest. A fill in the same cycle as a flush has no effect.
- R9: After reset the store is empty, `rsp_valid` is low and the recency order is the same as after a flush.
- R10: When a lookup and a fill occur in the same cycle, the lookup is answered against the state before the fill. The lookup's hit does not change the recency order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | ADDR_W | Lookup address (full tag) |
| fill_valid | input | 1 | Fill command strobe |
| fill_addr | input | ADDR_W | Address written as the new tag |
| flush | input | 1 | Invalidate all entries and reset the recency order |
| rsp_valid | output | 1 | Lookup response valid, one cycle after the request |
| rsp_hit | output | 1 | Lookup hit |
| rsp_idx | output | $clog2(ENTRIES) | Hitting entry, or the victim entry on a miss |

## Verification
The bench builds the block with four entries and 16-bit addresses. With four entries a few fills already fill the store, so the switch from choosing a free entry to choosing the LRU entry is reached early. Recency chains that wrap around the whole store also come up many times within a short run. The narrower address keeps the single-bit mismatch cases and the random address pool small, so repeated hits, duplicate fills and evictions happen often.

// File: rtl/fa_tag_pkg.sv
package fa_tag_pkg;
    localparam int unsigned FA_ADDR_W_DEF  = 32;
    localparam int unsigned FA_ENTRIES_DEF = 8;

    // Kind of recency update applied in a cycle
    typedef enum logic [1:0] {
        TOUCH_NONE  = 2'd0,
        TOUCH_HIT   = 2'd1,
        TOUCH_FILL  = 2'd2,
        TOUCH_RESET = 2'd3
    } touch_kind_e;
endpackage

// File: rtl/fa_tag_match.sv
module fa_tag_match #(
    parameter int unsigned ADDR_W  = fa_tag_pkg::FA_ADDR_W_DEF,
    parameter int unsigned ENTRIES = fa_tag_pkg::FA_ENTRIES_DEF,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                key,
    input  logic [ENTRIES-1:0]               valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0]   tags,
    output logic                             hit,
    output logic [IDX_W-1:0]                 hit_idx
);
    logic [ENTRIES-1:0] match_vec;

    // one comparator per entry, all in parallel
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign hit = |match_vec;

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec)) else $error("duplicate tag match"); // R7
endmodule

// File: rtl/fa_victim_pick.sv
module fa_victim_pick #(
    parameter int unsigned ENTRIES = fa_tag_pkg::FA_ENTRIES_DEF,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][IDX_W-1:0]  age,
    output logic [IDX_W-1:0]               victim
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] free_idx;
    logic             free_any;
    logic [IDX_W-1:0] lru_idx;

    always_comb begin
        free_idx = '0;
        free_any = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                free_any = 1'b1;
            end
        end
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (age[i] == OLDEST) begin
                lru_idx = IDX_W'(i);
            end
        end
    end

    assign victim = free_any ? free_idx : lru_idx;

    AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        !(&valid) |-> !valid[victim]) else $error("valid victim while free exists"); // R3
    AST_LRU_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid) |-> (age[victim] == OLDEST)) else $error("victim not LRU"); // R4
endmodule

// File: rtl/fa_recency.sv
module fa_recency #(
    parameter int unsigned ENTRIES = fa_tag_pkg::FA_ENTRIES_DEF,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ENTRIES-1:0][IDX_W-1:0]  age_q,
    input  fa_tag_pkg::touch_kind_e        kind,
    input  logic [IDX_W-1:0]               touch_idx,
    output logic [ENTRIES-1:0][IDX_W-1:0]  age_d
);
    import fa_tag_pkg::*;

    // age 0 = most recent, ENTRIES-1 = least recent
    always_comb begin
        age_d = age_q;
        unique case (kind)
            TOUCH_RESET: begin
                for (int i = 0; i < ENTRIES; i++) begin
                    age_d[i] = IDX_W'(ENTRIES - 1 - i);
                end
            end
            TOUCH_HIT, TOUCH_FILL: begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (IDX_W'(i) == touch_idx) begin
                        age_d[i] = '0;
                    end else if (age_q[i] < age_q[touch_idx]) begin
                        age_d[i] = age_q[i] + 1'b1;
                    end
                end
            end
            default: age_d = age_q;
        endcase
    end

    logic [ENTRIES-1:0] seen;
    always_comb begin
        seen = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            seen[age_q[i]] = 1'b1;
        end
    end

    AST_AGE_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == ENTRIES) else $error("recency order corrupt"); // R5
    AST_TOUCH_IS_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == TOUCH_HIT) |=> (age_q[$past(touch_idx)] == '0)) else $error("touched entry not MRU"); // R5
endmodule

// File: rtl/fa_tag_lookup.sv
module fa_tag_lookup #(
    parameter int unsigned ADDR_W  = fa_tag_pkg::FA_ADDR_W_DEF,
    parameter int unsigned ENTRIES = fa_tag_pkg::FA_ENTRIES_DEF,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              flush,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx
);
    import fa_tag_pkg::*;

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][ADDR_W-1:0] tag;
        logic [ENTRIES-1:0][IDX_W-1:0]  age;
        logic                           rsp_valid;
        logic                           rsp_hit;
        logic [IDX_W-1:0]               rsp_idx;
    } state_t;

    function automatic state_t state_reset();
        state_t s;
        s = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            s.age[i] = IDX_W'(ENTRIES - 1 - i);
        end
        return s;
    endfunction

    state_t st_q, st_d;

    logic             lk_hit, fill_hit;
    logic [IDX_W-1:0] lk_hit_idx, fill_hit_idx, victim_idx;
    logic [IDX_W-1:0] fill_tgt, touch_idx;
    touch_kind_e      touch_kind;
    logic [ENTRIES-1:0][IDX_W-1:0] age_nxt;

    fa_tag_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_lk_match (
        .clk(clk), .rst_n(rst_n), .key(lk_addr), .valid(st_q.valid),
        .tags(st_q.tag), .hit(lk_hit), .hit_idx(lk_hit_idx)
    );

    fa_tag_match #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_fill_match (
        .clk(clk), .rst_n(rst_n), .key(fill_addr), .valid(st_q.valid),
        .tags(st_q.tag), .hit(fill_hit), .hit_idx(fill_hit_idx)
    );

    fa_victim_pick #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid(st_q.valid), .age(st_q.age),
        .victim(victim_idx)
    );

    fa_recency #(.ENTRIES(ENTRIES)) u_recency (
        .clk(clk), .rst_n(rst_n), .age_q(st_q.age), .kind(touch_kind),
        .touch_idx(touch_idx), .age_d(age_nxt)
    );

    // select the recency update for this cycle
    always_comb begin
        fill_tgt = fill_hit ? fill_hit_idx : victim_idx;
        if (flush) begin
            touch_kind = TOUCH_RESET;
            touch_idx  = '0;
        end else if (fill_valid) begin
            touch_kind = TOUCH_FILL;
            touch_idx  = fill_tgt;
        end else if (lk_valid && lk_hit) begin
            touch_kind = TOUCH_HIT;
            touch_idx  = lk_hit_idx;
        end else begin
            touch_kind = TOUCH_NONE;
            touch_idx  = '0;
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.age       = age_nxt;
        st_d.rsp_valid = lk_valid;
        if (lk_valid) begin
            st_d.rsp_hit = lk_hit;
            st_d.rsp_idx = lk_hit ? lk_hit_idx : victim_idx;
        end
        if (flush) begin
            st_d.valid = '0;
        end else if (fill_valid) begin
            st_d.valid[fill_tgt] = 1'b1;
            st_d.tag[fill_tgt]   = fill_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= state_reset();
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_hit   = st_q.rsp_hit;
    assign rsp_idx   = st_q.rsp_idx;

    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid) else $error("missing response"); // R2
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid) else $error("spurious response"); // R2
    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.valid == '0)) else $error("flush left valid entry"); // R8
    AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=> st_q.valid[$past(fill_tgt)]) else $error("fill target invalid"); // R6
    AST_FILL_REUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush && fill_hit) |=> $stable(st_q.valid)) else $error("duplicate fill allocated"); // R7
endmodule

// File: tb/fa_tag_lookup_tb.sv
`timescale 1ns/1ps
module fa_tag_lookup_tb_top;
    localparam int AW = 16;
    localparam int NE = 4;
    localparam int IW = $clog2(NE);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0, fill_valid = 1'b0, flush = 1'b0;
    logic [AW-1:0] lk_addr = '0, fill_addr = '0;
    logic          rsp_valid, rsp_hit;
    logic [IW-1:0] rsp_idx;

    int tests = 0, fails = 0, cycles = 0;
    bit done = 0;

    // reference model
    bit       m_val[NE];
    int       m_tag[NE];
    int       m_ord[$];   // front = oldest

    always #2.5 clk = ~clk;

    fa_tag_lookup #(.ADDR_W(AW), .ENTRIES(NE)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog: run hung after %0d cycles, expected completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic void m_reset();
        m_ord.delete();
        for (int i = 0; i < NE; i++) begin
            m_val[i] = 0;
            m_tag[i] = 0;
            m_ord.push_back(i);
        end
    endfunction

    function automatic void m_touch(int e);
        for (int i = 0; i < m_ord.size(); i++) begin
            if (m_ord[i] == e) begin
                m_ord.delete(i);
                break;
            end
        end
        m_ord.push_back(e);
    endfunction

    function automatic int m_find(int a);
        for (int i = 0; i < NE; i++) if (m_val[i] && m_tag[i] == a) return i;
        return -1;
    endfunction

    function automatic int m_victim();
        for (int i = 0; i < NE; i++) if (!m_val[i]) return i;
        return m_ord[0];
    endfunction

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, update model, compare at following negedge
    task automatic step(string req, bit lv, int la, bit fv, int fa, bit fl);
        int eh, ei, k;
        lk_valid = lv; lk_addr = AW'(la);
        fill_valid = fv; fill_addr = AW'(fa); flush = fl;
        k  = m_find(la);
        eh = (k >= 0);
        ei = eh ? k : m_victim();
        if (fl) begin
            m_reset();
        end else if (fv) begin
            k = m_find(fa);
            if (k < 0) begin
                k = m_victim();
                m_val[k] = 1;
                m_tag[k] = fa;
            end
            m_touch(k);
        end else if (lv && eh) begin
            m_touch(ei);
        end
        @(posedge clk);
        @(negedge clk);
        check(req, "rsp_valid", int'(rsp_valid), int'(lv));
        if (lv) begin
            check(req, "rsp_hit", int'(rsp_hit), eh);
            check(req, "rsp_idx", int'(rsp_idx), ei);
        end
    endtask

    task automatic look(string req, int a);
        step(req, 1, a, 0, 0, 0);
    endtask

    task automatic fill(string req, int a);
        step(req, 0, 0, 1, a, 0);
    endtask

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        check("R9", "rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "rsp_valid after reset", int'(rsp_valid), 0);
        look("R9 R3", 16'h1234);          // empty: miss, victim 0
        step("R2", 0, 0, 0, 0, 0);        // idle, no response
        fill("R6", 16'h1234);
        fill("R6", 16'h5678);
        look("R1", 16'h1234);             // hit entry 0
        look("R1", 16'h1235);             // single bit differs: miss
        look("R1", 16'h9234);             // top bit differs: miss
        look("R3", 16'h0001);             // victim lowest free = 2
        fill("R7", 16'h1234);             // duplicate reuses entry 0
        look("R7", 16'h0002);             // still victim 2
        fill("R6", 16'hAAAA);
        fill("R6", 16'hBBBB);             // full
        look("R4", 16'hCCCC);             // victim LRU
        look("R5", 16'h5678);             // touch entry 1
        look("R4 R5", 16'hCCCC);
        step("R10", 1, 16'hDDDD, 1, 16'hDDDD, 0); // lookup misses on pre-fill state
        step("R10", 1, 16'hAAAA, 1, 16'hEEEE, 0);
        look("R10", 16'hCCCC);
        look("R10", 16'hEEEE);
        step("R8", 1, 16'hEEEE, 0, 0, 1); // flush with lookup: pre-flush hit
        look("R8", 16'hEEEE);             // now miss, victim 0
        step("R8", 0, 0, 1, 16'h4444, 1); // fill ignored under flush
        look("R8", 16'h4444);
        // refill and check restored order reaches LRU = entry 0
        for (int i = 0; i < NE; i++) fill("R8", 16'h2000 + i);
        look("R8 R4", 16'h7777);
        // pseudo-random mix over a small address pool
        for (int n = 0; n < 400; n++) begin
            int r, la, fa;
            r  = $urandom_range(0, 99);
            la = 16'h3000 + $urandom_range(0, 6) * 16'h0101;
            fa = 16'h3000 + $urandom_range(0, 6) * 16'h0101;
            step("R4 R5 R6 R7", r < 70, la, (r % 3) == 0, fa, r == 99);
        end
        lk_valid = 0; fill_valid = 0; flush = 0;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule